// File: doc/BRIEF.md
# Masked Event Interrupt Pulse Generator

This block sits between the status logic of a power-management controller and the interrupt line to a host processor. It watches a group of live status inputs and turns their events into a fixed-width, active-low pulse on one interrupt output. The pulse lasts 256 µs at the configured clock. Each single-bit status input counts as an event when it rises. The charge-state code and the thermistor-zone code count as an event when their value changes in any way.

Every source has a sticky flag and a mask bit. An event always sets its flag. Only an event whose mask bit is clear can start a pulse. The host reads all flags at once through a simple register port, and that read clears them. The same port writes the mask bits. One pulse is sent after reset to tell the host that the register interface is ready. The pulse timer is separate from the flags. An event that arrives while a pulse is running only records its flag.

Top module: `irq_pulse_top`

## Requirements
- R1: While `rst` is high, `int_n_o` is 1, `rd_data_o` is all zeros and `mask_o` is all zeros.
- R2: On the first clock edge after `rst` falls, `int_n_o` goes low. This is the ready pulse, and it needs no event.
- R3: Every pulse keeps `int_n_o` low for exactly PULSE_CYC clock cycles, where PULSE_CYC = (CLK_HZ / 1 000 000) × PULSE_US. With the defaults this is 256. Then the output returns high.
- R4: Bit i of `stat_bits_i` sets flag bit i only on a 0-to-1 transition. The flag becomes visible on `rd_data_o` three clock edges after the new input value is sampled. A bit that stays high, or that falls, sets nothing.
- R5: Any change in the value of `chg_code_i` sets flag bit N_BIT.
- R6: A change in any bit of `ts_code_i` sets flag bit N_BIT+1.
- R7: A set flag stays set, whatever its status input does later, until the host reads the flags.
- R8: A clock cycle with `rd_i` high clears every flag bit that is not newly set in that same cycle.
- R9: An event whose mask bit is 1 sets its flag but does not start a pulse.
- R10: An unmasked event during a running pulse neither restarts nor extends that pulse.
- R11: If an event and a host read fall in the same cycle, the flag for that event is 1 after the cycle.
- R12: A cycle with `wr_mask_i` high loads `mask_wdata_i` into the mask register. The new value shows on `mask_o` after that edge. Mask bit k guards flag bit k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stat_bits_i | input | N_BIT | Live single-bit status inputs (asynchronous) |
| chg_code_i | input | CHG_W | Live charge-state code (asynchronous) |
| ts_code_i | input | TS_W | Live thermistor-zone code (asynchronous) |
| rd_i | input | 1 | Host flag read strobe; clears the flags |
| rd_data_o | output | N_BIT+2 | Current flag register |
| wr_mask_i | input | 1 | Host mask write strobe |
| mask_wdata_i | input | N_BIT+2 | Mask value to write |
| mask_o | output | N_BIT+2 | Current mask register |
| int_n_o | output | 1 | Active-low interrupt pulse output |

## Verification
Two pairs of functions can fall in the same clock cycle. The first pair is a host read and a new event. The second pair is a running pulse and a new unmasked event. The bench provokes the first pair on purpose: it raises a status input and then places the read strobe exactly on the third edge after that input was sampled. It then expects the flag to be set after the read. For the second pair, the bench raises a second source in the middle of a pulse and counts the low cycles from the start of the pulse. The total must still equal the nominal width. Random traffic adds many more such collisions. A behavioural model checks them every cycle for flags, mask and the interrupt line.

// File: rtl/irq_pkg.sv
package irq_pkg;

    // Pulse length in clock cycles for a given clock rate and pulse width in microseconds.
    function automatic int unsigned pulse_cycles(input int unsigned clk_hz,
                                                 input int unsigned width_us);
        int unsigned per_us;
        per_us = clk_hz / 1_000_000;
        if (per_us == 0) per_us = 1;
        return per_us * width_us;
    endfunction

    typedef enum logic {
        PT_IDLE = 1'b0,
        PT_LOW  = 1'b1
    } pt_state_e;

endpackage

// File: rtl/evt_detect.sv
module evt_detect #(
    parameter int N_BIT = 8,
    parameter int CHG_W = 3,
    parameter int TS_W  = 4,
    localparam int IW   = N_BIT + CHG_W + TS_W,
    localparam int NSRC = N_BIT + 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_BIT-1:0] bits_i,
    input  logic [CHG_W-1:0] chg_i,
    input  logic [TS_W-1:0]  ts_i,
    output logic [NSRC-1:0]  ev_o
);
    localparam int CHG_LO = N_BIT;
    localparam int TS_LO  = N_BIT + CHG_W;

    logic [IW-1:0] raw;
    logic [IW-1:0] sync1_q, sync2_q, prev_q;

    assign raw = {ts_i, chg_i, bits_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= '0;
            sync2_q <= '0;
            prev_q  <= '0;
        end else begin
            sync1_q <= raw;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    generate
        for (genvar i = 0; i < N_BIT; i++) begin : g_rise
            assign ev_o[i] = sync2_q[i] & ~prev_q[i];
        end
    endgenerate

    assign ev_o[N_BIT]   = sync2_q[CHG_LO +: CHG_W] != prev_q[CHG_LO +: CHG_W];
    assign ev_o[N_BIT+1] = sync2_q[TS_LO +: TS_W]   != prev_q[TS_LO +: TS_W];

    // a rising-edge event always follows a low sample in the previous stage
    assert_rise_needs_low_R4: assert property (@(posedge clk) disable iff (rst)
        ev_o[0] |=> $past(prev_q[0]) == 1'b0 && prev_q[0]);

endmodule

// File: rtl/flag_bank.sv
module flag_bank #(
    parameter int NSRC = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] ev_i,
    input  logic            rd_i,
    input  logic            wr_i,
    input  logic [NSRC-1:0] wdata_i,
    output logic [NSRC-1:0] flags_o,
    output logic [NSRC-1:0] mask_o,
    output logic            fire_o
);
    logic [NSRC-1:0] flags_q, mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            mask_q  <= '0;
        end else begin
            flags_q <= (rd_i ? '0 : flags_q) | ev_i;
            if (wr_i) mask_q <= wdata_i;
        end
    end

    assign flags_o = flags_q;
    assign mask_o  = mask_q;
    assign fire_o  = |(ev_i & ~mask_q);

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        !rd_i |=> (flags_q & $past(flags_q)) == $past(flags_q));

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
        rd_i |=> (flags_q & ~$past(ev_i)) == '0);

    assert_set_beats_clear_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_i && (ev_i != '0)) |=> (flags_q & $past(ev_i)) == $past(ev_i));

    assert_mask_write_R12: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> mask_q == $past(wdata_i));

endmodule

// File: rtl/pulse_gen.sv
module pulse_gen
    import irq_pkg::*;
#(
    parameter int PULSE_CYC = 256,
    localparam int CW = $clog2(PULSE_CYC + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_i,
    output logic int_n_o
);
    localparam logic [CW-1:0] LOAD = CW'(PULSE_CYC);

    pt_state_e     state_q;
    logic [CW-1:0] cnt_q;
    logic          ready_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PT_IDLE;
            cnt_q   <= '0;
            ready_q <= 1'b1;
        end else begin
            ready_q <= 1'b0;
            case (state_q)
                PT_IDLE: begin
                    if (trig_i || ready_q) begin
                        state_q <= PT_LOW;
                        cnt_q   <= LOAD;
                    end
                end
                PT_LOW: begin
                    cnt_q <= cnt_q - 1'b1;
                    if (cnt_q == CW'(1)) state_q <= PT_IDLE;
                end
                default: state_q <= PT_IDLE;
            endcase
        end
    end

    assign int_n_o = (state_q == PT_IDLE);

    assert_fall_has_cause_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(int_n_o) |-> $past(trig_i || ready_q));

    assert_no_retrigger_R10: assert property (@(posedge clk) disable iff (rst)
        (state_q == PT_LOW) |=> cnt_q != LOAD);

endmodule

// File: rtl/irq_pulse_top.sv
module irq_pulse_top
    import irq_pkg::*;
#(
    parameter int N_BIT    = 8,
    parameter int CHG_W    = 3,
    parameter int TS_W     = 4,
    parameter int CLK_HZ   = 1_000_000,
    parameter int PULSE_US = 256,
    localparam int NSRC      = N_BIT + 2,
    localparam int PULSE_CYC = int'(pulse_cycles(CLK_HZ, PULSE_US))
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_BIT-1:0] stat_bits_i,
    input  logic [CHG_W-1:0] chg_code_i,
    input  logic [TS_W-1:0]  ts_code_i,
    input  logic             rd_i,
    output logic [NSRC-1:0]  rd_data_o,
    input  logic             wr_mask_i,
    input  logic [NSRC-1:0]  mask_wdata_i,
    output logic [NSRC-1:0]  mask_o,
    output logic             int_n_o
);
    logic [NSRC-1:0] ev;
    logic            fire;

    evt_detect #(.N_BIT(N_BIT), .CHG_W(CHG_W), .TS_W(TS_W)) u_det (
        .clk    (clk),
        .rst    (rst),
        .bits_i (stat_bits_i),
        .chg_i  (chg_code_i),
        .ts_i   (ts_code_i),
        .ev_o   (ev)
    );

    flag_bank #(.NSRC(NSRC)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .ev_i    (ev),
        .rd_i    (rd_i),
        .wr_i    (wr_mask_i),
        .wdata_i (mask_wdata_i),
        .flags_o (rd_data_o),
        .mask_o  (mask_o),
        .fire_o  (fire)
    );

    pulse_gen #(.PULSE_CYC(PULSE_CYC)) u_pulse (
        .clk     (clk),
        .rst     (rst),
        .trig_i  (fire),
        .int_n_o (int_n_o)
    );

    // a masked-only event seen while idle must not pull the line low
    assert_mask_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (int_n_o && !fire && ((ev & mask_o) != '0) && !$rose(rst)) |=> int_n_o || $past(rst, 2));

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> int_n_o);

endmodule

// File: tb/sim_irq_pulse_top.sv
module sim_irq_pulse_top;
    localparam int NB = 8;
    localparam int CWD = 3;
    localparam int TW = 4;
    localparam int NS = NB + 2;
    localparam int IW = NB + CWD + TW;
    localparam int P  = 256;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NB-1:0] bits = '0;
    logic [CWD-1:0] chg = '0;
    logic [TW-1:0] ts = '0;
    logic          rd = 1'b0;
    logic          wr = 1'b0;
    logic [NS-1:0] wdata = '0;
    logic [NS-1:0] rdata, mask;
    logic          int_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_pulse_top u0 (
        .clk(clk), .rst(rst), .stat_bits_i(bits), .chg_code_i(chg), .ts_code_i(ts),
        .rd_i(rd), .rd_data_o(rdata), .wr_mask_i(wr), .mask_wdata_i(wdata),
        .mask_o(mask), .int_n_o(int_n)
    );

    // ---------------- behavioural model built from the requirements ----------------
    logic [IW-1:0] m1, m2, m3;
    logic [NS-1:0] m_flags, m_mask;
    int            m_cnt;
    bit            m_ready;

    function automatic logic [NS-1:0] exp_events(input logic [IW-1:0] cur, input logic [IW-1:0] old);
        logic [NS-1:0] e;
        for (int i = 0; i < NB; i++) e[i] = cur[i] & ~old[i];
        e[NB]   = cur[NB +: CWD] != old[NB +: CWD];
        e[NB+1] = cur[NB+CWD +: TW] != old[NB+CWD +: TW];
        return e;
    endfunction

    always @(posedge clk) begin
        logic [NS-1:0] e;
        if (rst) begin
            m1 = '0; m2 = '0; m3 = '0;
            m_flags = '0; m_mask = '0; m_cnt = 0; m_ready = 1'b1;
        end else begin
            e = exp_events(m2, m3);
            if (m_cnt != 0) m_cnt = m_cnt - 1;
            else if (m_ready || ((e & ~m_mask) != '0)) m_cnt = P;
            m_ready = 1'b0;
            m_flags = (rd ? '0 : m_flags) | e;
            if (wr) m_mask = wdata;
            m3 = m2; m2 = m1; m1 = {ts, chg, bits};
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock, then compare every output with the model at the falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        chk(int_n === (m_cnt == 0), "R3 int_n vs model", longint'(int_n), longint'(m_cnt == 0));
        chk(rdata === m_flags, "R7 flags vs model", longint'(rdata), longint'(m_flags));
        chk(mask === m_mask, "R12 mask vs model", longint'(mask), longint'(m_mask));
    endtask

    task automatic wait_idle();
        while (int_n !== 1'b1) tick();
        repeat (4) tick();
    endtask

    task automatic do_read();
        rd = 1'b1; tick(); rd = 1'b0;
    endtask

    initial begin
        int lows;
        int unused_seed;
        unused_seed = $urandom(32'h5EED_0042);
        @(negedge clk);
        // R1: reset state
        repeat (3) begin
            tick();
            chk(int_n === 1'b1 && rdata === '0 && mask === '0, "R1 reset outputs",
                longint'({int_n, rdata, mask}), longint'({1'b1, {NS{1'b0}}, {NS{1'b0}}}));
        end
        rst = 1'b0;
        tick();
        chk(int_n === 1'b0, "R2 ready pulse", longint'(int_n), 0);
        lows = 1;
        while (int_n === 1'b0) begin tick(); if (int_n === 1'b0) lows++; end
        chk(lows == P, "R3 ready pulse width", longint'(lows), longint'(P));
        wait_idle();

        // R4: rising edge on bit 0
        bits[0] = 1'b1;
        tick(); tick();
        chk(rdata[0] === 1'b0, "R4 latency before third edge", longint'(rdata[0]), 0);
        tick();
        chk(rdata[0] === 1'b1 && int_n === 1'b0, "R4 flag and pulse on rise",
            longint'({rdata[0], int_n}), 2);
        wait_idle();
        do_read();
        repeat (10) tick();
        chk(rdata[0] === 1'b0 && int_n === 1'b1, "R4 steady high gives no event",
            longint'({rdata[0], int_n}), 1);
        bits[0] = 1'b0;
        repeat (6) tick();
        chk(rdata[0] === 1'b0 && int_n === 1'b1, "R4 falling edge ignored",
            longint'({rdata[0], int_n}), 1);

        // R7: sticky flag after status returns low
        bits[1] = 1'b1; tick(); bits[1] = 1'b0;
        repeat (40) tick();
        chk(rdata[1] === 1'b1, "R7 flag sticky", longint'(rdata[1]), 1);
        wait_idle();
        // R8: read clears
        do_read();
        chk(rdata === '0, "R8 read clears", longint'(rdata), 0);

        // R5: charge code change, including to a completion code
        chg = 3'd5;
        repeat (3) tick();
        chk(rdata[NB] === 1'b1, "R5 charge code change", longint'(rdata[NB]), 1);
        wait_idle(); do_read();
        // R6: single thermistor bit change
        ts[2] = 1'b1;
        repeat (3) tick();
        chk(rdata[NB+1] === 1'b1, "R6 thermistor bit change", longint'(rdata[NB+1]), 1);
        wait_idle(); do_read();

        // R12 + R9: mask bit 2, its event sets the flag but no pulse
        wdata = NS'(1) << 2; wr = 1'b1; tick(); wr = 1'b0;
        chk(mask === (NS'(1) << 2), "R12 mask write", longint'(mask), longint'(NS'(1) << 2));
        bits[2] = 1'b1;
        repeat (8) tick();
        chk(rdata[2] === 1'b1 && int_n === 1'b1, "R9 masked event quiet",
            longint'({rdata[2], int_n}), 3);
        do_read();

        // R10: second event in the middle of a pulse
        bits[3] = 1'b1;
        repeat (3) tick();
        chk(int_n === 1'b0, "R10 pulse started", longint'(int_n), 0);
        lows = 1;
        repeat (50) begin tick(); if (int_n === 1'b0) lows++; end
        bits[4] = 1'b1;
        while (int_n === 1'b0) begin tick(); if (int_n === 1'b0) lows++; end
        chk(lows == P, "R10 pulse not extended", longint'(lows), longint'(P));
        chk(rdata[4] === 1'b1, "R10 late event flagged", longint'(rdata[4]), 1);
        wait_idle(); do_read();

        // R11: event and read in the same cycle
        bits[5] = 1'b1;
        tick(); tick();
        rd = 1'b1; tick(); rd = 1'b0;
        chk(rdata[5] === 1'b1, "R11 set wins over clear", longint'(rdata[5]), 1);
        wait_idle(); do_read();

        // random traffic, judged every cycle by the model
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(7) == 0) bits[$urandom_range(NB-1)] ^= 1'b1;
            if ($urandom_range(19) == 0) chg = CWD'($urandom);
            if ($urandom_range(19) == 0) ts[$urandom_range(TW-1)] ^= 1'b1;
            rd = ($urandom_range(9) == 0);
            wr = ($urandom_range(99) == 0);
            wdata = NS'($urandom);
            tick();
        end
        rd = 1'b0; wr = 1'b0;
        tick();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150_000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule